// File: doc/BRIEF.md
# Bit-Aligning Sync Word Frame Receiver

This block accepts a stream of received bytes whose boundaries have no fixed relation to the frame boundaries. The bits of each input byte arrive least significant bit first. The block looks for the 16-bit sync pattern 0xB24D starting at any bit position. Once it finds the pattern, it rebuilds every later frame byte from two neighbouring input bytes, using the bit position where the sync pattern ended.

After the sync word comes a length byte L. L counts itself plus the payload, so L-1 payload bytes follow. Two check bytes come after the payload. The block writes the frame into a buffer and runs a CRC over the rebuilt bytes. When the frame is complete, it raises a done flag together with a CRC result. The frame then stays frozen until the host pulses `clear`. While the frame is frozen, the host reads it back through a combinational read port.

The block does not do demodulation, timeouts or command decoding.

Top module: `sync_deframer`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `frame_done`, `frame_crc_ok` and `frame_error` are 0 and the block is hunting for a new sync word.
- R2: The sync word is found whatever the bit position of its first bit within an input byte (all 8 positions). Buffer index 0 reads 0xB2 and index 1 reads 0x4D. When the match ends on the last bit of an input byte, the whole next input byte is the length byte.
- R3: A sync attempt starts on any nonzero byte and is abandoned when a zero byte arrives before the match completes. Hunting then starts again on the next nonzero byte.
- R4: Stream bit n is bit n%8 of input byte n/8. Each rebuilt buffer byte holds its 8 stream bits in arrival order, with the first bit in bit 7.
- R5: The length byte L is stored at index 2. `frame_len` becomes L+4. After the length byte, L-1 payload bytes and then 2 check bytes are stored at indices 3 to L+3. `frame_done` rises after the input byte that completes the last check byte.
- R6: The CRC is CRC-16 with polynomial 0x1021 and initial value 0, computed MSB first over indices 2 to L+3. `frame_crc_ok` is 1 exactly when the remainder is zero, i.e. when the check bytes carry the CRC of the length byte and payload with the high byte first. A corrupted frame still sets `frame_done`, with `frame_crc_ok` = 0.
- R7: While `frame_done` is 1, input bytes are ignored: the buffer, `frame_len` and `frame_crc_ok` stay unchanged until `clear`.
- R8: A length byte of 0, or one with L+4 greater than DEPTH, drops the frame: `frame_error` is set, `frame_done` stays 0, and hunting resumes. A frame with L+4 equal to DEPTH is accepted.
- R9: With L = 1 there is no payload, and the two check bytes follow the length byte directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Releases a held or dropped frame and restarts the hunt |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte, first-arrived bit in bit 0 |
| rd_addr | input | $clog2(DEPTH) | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_addr` (combinational) |
| frame_done | output | 1 | A complete frame is held |
| frame_crc_ok | output | 1 | The held frame has a zero CRC remainder |
| frame_error | output | 1 | A frame was dropped because its length byte was invalid |
| frame_len | output | $clog2(DEPTH+1) | Stored frame size, L+4 |

## Verification
The bench builds bit streams in which the sync word starts at each of the eight bit positions. It combines these with lengths from the no-payload case up to a frame that fills the buffer exactly. This separates the offset-8 case, where the length byte is a whole input byte, from the seven cases where every byte is rebuilt across two input bytes. A frame with one flipped payload bit separates CRC checking from simple framing. A zero byte inserted inside the sync word shows that an attempt is abandoned and that hunting restarts. A second frame sent while one is held shows that held data cannot be disturbed. Length bytes of 0 and DEPTH-3 exercise the drop path on both sides of the valid range.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SYNCING,
    ST_LEN,
    ST_DATA,
    ST_CHECK,
    ST_HELD
  } dfr_state_e;

  localparam logic [15:0] SYNC_PATTERN = 16'hB24D;
  localparam logic [15:0] CRC_POLY     = 16'h1021;

  // Bit order reversal: first-arrived bit (bit 0) moves to bit 7.
  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // One byte of CRC-16, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    logic        fb;
    x = c;
    for (int i = 7; i >= 0; i--) begin
      fb = x[15] ^ d[i];
      x  = {x[14:0], 1'b0};
      if (fb) x = x ^ CRC_POLY;
    end
    return x;
  endfunction

endpackage

// File: rtl/sync_hunter.sv
module sync_hunter
  import deframer_pkg::*;
#(
  parameter logic [15:0] PATTERN = SYNC_PATTERN
) (
  input  logic [15:0] shreg,
  input  logic [7:0]  byte_in,
  output logic        hit,
  output logic [3:0]  hit_pos,
  output logic [15:0] next_shreg
);
  // Arrival-ordered bits: the oldest bit is at the top.
  logic [23:0] cat;
  logic [7:0]  match;

  assign cat        = {shreg, bit_rev8(byte_in)};
  assign next_shreg = cat[15:0];

  // Window seen after k new bits have been shifted in.
  for (genvar k = 1; k <= 8; k++) begin : g_win
    assign match[k-1] = (cat[23-k -: 16] == PATTERN);
  end

  // The earliest position wins.
  always_comb begin
    hit     = 1'b0;
    hit_pos = 4'd0;
    for (int k = 8; k >= 1; k--) begin
      if (match[k-1]) begin
        hit     = 1'b1;
        hit_pos = 4'(k);
      end
    end
  end
endmodule

// File: rtl/byte_repacker.sv
module byte_repacker
  import deframer_pkg::*;
(
  input  logic [7:0] partial,
  input  logic [7:0] byte_in,
  input  logic [3:0] offset,
  output logic [7:0] packed_byte,
  output logic [7:0] next_partial
);
  // offset = number of bits of the new byte that finish the current frame
  // byte (1..8). The low 8-offset bits of partial are the older bits.
  logic [15:0] w;
  logic [15:0] sh;

  assign next_partial = bit_rev8(byte_in);
  assign w            = {partial, next_partial};
  assign sh           = w >> (4'd8 - offset);
  assign packed_byte  = sh[7:0];
endmodule

// File: rtl/crc16_acc.sv
module crc16_acc
  import deframer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_next
);
  logic [15:0] crc_q;

  assign crc_next = crc16_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n || start) crc_q <= '0;
    else if (en)         crc_q <= crc_next;
  end
endmodule

// File: rtl/frame_store.sv
module frame_store #(
  parameter int DEPTH = 260,
  localparam int AW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Indices 0 and 1 always hold the sync word.
  always_comb begin
    if (raddr == AW'(0))      rdata = 8'hB2;
    else if (raddr == AW'(1)) rdata = 8'h4D;
    else                      rdata = mem[raddr];
  end
endmodule

// File: rtl/sync_deframer.sv
module sync_deframer
  import deframer_pkg::*;
#(
  parameter int DEPTH = 260,
  localparam int AW  = $clog2(DEPTH),
  localparam int LW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          frame_done,
  output logic          frame_crc_ok,
  output logic          frame_error,
  output logic [LW-1:0] frame_len
);
  dfr_state_e    state_q;
  logic [15:0]   shreg_q;
  logic [7:0]    partial_q;
  logic [3:0]    offset_q;
  logic [AW-1:0] ptr_q;
  logic [7:0]    remain_q;
  logic [LW-1:0] len_q;
  logic          done_q, crcok_q, err_q;

  logic          hit;
  logic [3:0]    hit_pos;
  logic [15:0]   next_shreg;
  logic [7:0]    packed_byte, next_partial;
  logic [15:0]   crc_next;
  logic [8:0]    need;
  logic          len_bad;
  logic          take;

  // Named internal events
  logic          sync_hit_ev;
  logic          byte_wr_ev;
  logic          drop_ev;
  logic          frame_end_ev;
  logic [AW-1:0] waddr;

  sync_hunter u_hunt (
    .shreg(shreg_q), .byte_in(in_byte),
    .hit(hit), .hit_pos(hit_pos), .next_shreg(next_shreg)
  );

  byte_repacker u_pack (
    .partial(partial_q), .byte_in(in_byte), .offset(offset_q),
    .packed_byte(packed_byte), .next_partial(next_partial)
  );

  assign take    = in_valid && !clear;
  assign need    = {1'b0, packed_byte} + 9'd4;
  assign len_bad = (packed_byte == 8'd0) || (int'(need) > DEPTH);

  assign sync_hit_ev  = take && (state_q == ST_SYNCING) && (in_byte != 8'd0) && hit;
  assign drop_ev      = take && (state_q == ST_LEN) && len_bad;
  assign byte_wr_ev   = take && (((state_q == ST_LEN) && !len_bad) ||
                                 (state_q == ST_DATA) || (state_q == ST_CHECK));
  assign frame_end_ev = take && (state_q == ST_CHECK) && (remain_q == 8'd1);
  assign waddr        = (state_q == ST_LEN) ? AW'(2) : ptr_q;

  crc16_acc u_crc (
    .clk(clk), .rst_n(rst_n), .start(sync_hit_ev),
    .en(byte_wr_ev), .din(packed_byte), .crc_next(crc_next)
  );

  frame_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(byte_wr_ev), .waddr(waddr), .wdata(packed_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state_q   <= ST_HUNT;
      shreg_q   <= '0;
      partial_q <= '0;
      offset_q  <= 4'd8;
      ptr_q     <= '0;
      remain_q  <= '0;
      len_q     <= '0;
      done_q    <= 1'b0;
      crcok_q   <= 1'b0;
      err_q     <= 1'b0;
    end else if (in_valid) begin
      unique case (state_q)
        ST_HUNT: begin
          if (in_byte != 8'd0) begin
            shreg_q <= {8'h00, bit_rev8(in_byte)};
            state_q <= ST_SYNCING;
          end
        end
        ST_SYNCING: begin
          if (in_byte == 8'd0) begin
            state_q <= ST_HUNT;
          end else if (hit) begin
            offset_q  <= hit_pos;
            partial_q <= next_partial;
            state_q   <= ST_LEN;
          end else begin
            shreg_q <= next_shreg;
          end
        end
        ST_LEN: begin
          partial_q <= next_partial;
          if (len_bad) begin
            err_q   <= 1'b1;
            state_q <= ST_HUNT;
          end else begin
            len_q <= LW'(need);
            ptr_q <= AW'(3);
            if (packed_byte == 8'd1) begin
              remain_q <= 8'd2;
              state_q  <= ST_CHECK;
            end else begin
              remain_q <= packed_byte - 8'd1;
              state_q  <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          partial_q <= next_partial;
          ptr_q     <= ptr_q + AW'(1);
          if (remain_q == 8'd1) begin
            remain_q <= 8'd2;
            state_q  <= ST_CHECK;
          end else begin
            remain_q <= remain_q - 8'd1;
          end
        end
        ST_CHECK: begin
          partial_q <= next_partial;
          ptr_q     <= ptr_q + AW'(1);
          remain_q  <= remain_q - 8'd1;
          if (remain_q == 8'd1) begin
            done_q  <= 1'b1;
            crcok_q <= (crc_next == 16'd0);
            state_q <= ST_HELD;
          end
        end
        ST_HELD: ;
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign frame_done   = done_q;
  assign frame_crc_ok = crcok_q;
  assign frame_error  = err_q;
  assign frame_len    = len_q;
endmodule

// File: rtl/deframer_checker.sv
module deframer_checker #(
  parameter int DEPTH = 260,
  localparam int LW  = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_valid,
  input logic          frame_done,
  input logic          frame_crc_ok,
  input logic          frame_error,
  input logic [LW-1:0] frame_len,
  input logic          sync_hit_ev,
  input logic          byte_wr_ev,
  input logic          drop_ev,
  input logic          frame_end_ev
);
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!frame_done && !frame_crc_ok && !frame_error));

  assert_events_need_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit_ev || byte_wr_ev || drop_ev) |-> in_valid);

  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_hit_ev, byte_wr_ev, drop_ev}));

  assert_end_raises_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_ev |=> frame_done);

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (int'(frame_len) >= 5 && int'(frame_len) <= DEPTH));

  assert_crcok_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_crc_ok |-> frame_done);

  assert_hold_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !clear) |=> (frame_done && $stable(frame_len) && $stable(frame_crc_ok)));

  assert_no_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !byte_wr_ev);

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (frame_error && !frame_done));
endmodule

bind sync_deframer deframer_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .frame_done(frame_done), .frame_crc_ok(frame_crc_ok),
  .frame_error(frame_error), .frame_len(frame_len),
  .sync_hit_ev(sync_hit_ev), .byte_wr_ev(byte_wr_ev),
  .drop_ev(drop_ev), .frame_end_ev(frame_end_ev)
);

// File: tb/sync_deframer_tb.sv
module sync_deframer_tb;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          frame_done, frame_crc_ok, frame_error;
  logic [LW-1:0] frame_len;

  always #4 clk = ~clk;

  sync_deframer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_byte(in_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_done(frame_done), .frame_crc_ok(frame_crc_ok),
    .frame_error(frame_error), .frame_len(frame_len)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_frame [0:63];
  logic [7:0] keep      [0:63];
  logic       sbits     [0:1023];
  logic [7:0] obytes    [0:127];
  int         nbits, nbytes;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // CRC as remainder of (message * x^16) modulo the generator, bit by bit.
  function automatic logic [15:0] ref_crc(input int nb);
    logic [15:0] r = 16'h0;
    logic        b, top;
    for (int i = 0; i < nb * 8 + 16; i++) begin
      b   = (i < nb * 8) ? exp_frame[2 + i / 8][7 - (i % 8)] : 1'b0;
      top = r[15];
      r   = {r[14:0], b};
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic make_frame(input int len, input int p, input bit corrupt);
    logic [15:0] c;
    exp_frame[0] = 8'hB2;
    exp_frame[1] = 8'h4D;
    exp_frame[2] = 8'(len);
    for (int i = 0; i < len - 1; i++) exp_frame[3 + i] = 8'(len * 7 + i * 29 + p * 3 + 1);
    c = ref_crc(len);
    exp_frame[len + 2] = c[15:8];
    exp_frame[len + 3] = c[7:0];
    if (corrupt) exp_frame[3] = exp_frame[3] ^ 8'h10;
  endtask

  task automatic serialize(input int p, input int nfb);
    nbits = 0;
    for (int i = 0; i < p; i++) begin sbits[nbits] = 1'b0; nbits++; end
    for (int b = 0; b < nfb; b++)
      for (int j = 7; j >= 0; j--) begin sbits[nbits] = exp_frame[b][j]; nbits++; end
    while (nbits % 8 != 0) begin sbits[nbits] = 1'b0; nbits++; end
    for (int i = 0; i < 16; i++) begin sbits[nbits] = 1'b0; nbits++; end
    nbytes = nbits / 8;
    for (int k = 0; k < nbytes; k++)
      for (int j = 0; j < 8; j++) obytes[k][j] = sbits[8 * k + j];
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_from(input int first);
    for (int k = first; k < nbytes; k++) send_byte(obytes[k]);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic check_buf(input int len, input string req);
    int bad_i = -1;
    int act = 0;
    int exp = 0;
    for (int i = 0; i < len + 4; i++) begin
      rd_addr = AW'(i);
      #1;
      if (bad_i < 0 && rd_data !== exp_frame[i]) begin
        bad_i = i; act = int'(rd_data); exp = int'(exp_frame[i]);
      end
    end
    check(bad_i < 0, req, act, exp);
  endtask

  task automatic full_frame(input int len, input int p, input bit corrupt);
    do_clear();
    make_frame(len, p, corrupt);
    serialize(p, len + 4);
    send_byte(8'h00);
    send_byte(8'h00);
    send_from(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lens [5] = '{1, 2, 5, 13, 28};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(frame_done == 1'b0,   "R1 done after reset", int'(frame_done), 0);
    check(frame_crc_ok == 1'b0, "R1 crc_ok after reset", int'(frame_crc_ok), 0);
    check(frame_error == 1'b0,  "R1 error after reset", int'(frame_error), 0);

    // R2/R4/R5/R6/R9: every bit offset against several lengths
    foreach (lens[li]) begin
      for (int p = 0; p < 8; p++) begin
        full_frame(lens[li], p, 1'b0);
        check(frame_done == 1'b1, (lens[li] == 1) ? "R9 done no payload" : "R2 done at offset",
              int'(frame_done), 1);
        check(frame_crc_ok == 1'b1, "R6 crc ok", int'(frame_crc_ok), 1);
        check(int'(frame_len) == lens[li] + 4,
              (lens[li] == 28) ? "R8 full-size length" : "R5 frame_len", int'(frame_len), lens[li] + 4);
        check_buf(lens[li], "R4 buffer contents");
      end
    end

    // R6: corrupted payload
    full_frame(6, 5, 1'b1);
    check(frame_done == 1'b1,   "R6 done on bad crc", int'(frame_done), 1);
    check(frame_crc_ok == 1'b0, "R6 crc flags error", int'(frame_crc_ok), 0);
    check_buf(6, "R4 corrupted buffer");

    // R7: a held frame ignores further input
    full_frame(5, 2, 1'b0);
    for (int i = 0; i < 64; i++) keep[i] = exp_frame[i];
    make_frame(2, 6, 1'b0);
    serialize(6, 6);
    send_byte(8'h00);
    send_from(0);
    for (int i = 0; i < 64; i++) exp_frame[i] = keep[i];
    check(frame_done == 1'b1,   "R7 still done", int'(frame_done), 1);
    check(int'(frame_len) == 9, "R7 length held", int'(frame_len), 9);
    check(frame_crc_ok == 1'b1, "R7 crc held", int'(frame_crc_ok), 1);
    check_buf(5, "R7 buffer held");

    // R3: zero byte inside the sync word abandons the attempt
    do_clear();
    make_frame(1, 4, 1'b0);
    serialize(4, 5);
    send_byte(8'h00);
    send_byte(obytes[0]);
    send_byte(8'h00);
    send_from(1);
    check(frame_done == 1'b0,  "R3 no frame after abort", int'(frame_done), 0);
    check(frame_error == 1'b0, "R3 no error after abort", int'(frame_error), 0);
    make_frame(2, 3, 1'b0);
    serialize(3, 6);
    send_from(0);
    check(frame_done == 1'b1, "R3 hunt restarts", int'(frame_done), 1);
    check_buf(2, "R3 buffer after restart");

    // R8: too long for the buffer
    do_clear();
    exp_frame[0] = 8'hB2; exp_frame[1] = 8'h4D; exp_frame[2] = 8'(DEPTH - 3);
    serialize(1, 3);
    send_byte(8'h00);
    send_from(0);
    check(frame_error == 1'b1, "R8 overflow error", int'(frame_error), 1);
    check(frame_done == 1'b0,  "R8 overflow not done", int'(frame_done), 0);
    do_clear();
    check(frame_error == 1'b0, "R1 clear drops error", int'(frame_error), 0);

    // R8: zero length
    exp_frame[2] = 8'h00;
    serialize(7, 3);
    send_byte(8'h00);
    send_from(0);
    check(frame_error == 1'b1, "R8 zero length error", int'(frame_error), 1);
    check(frame_done == 1'b0,  "R8 zero length not done", int'(frame_done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule